// File: doc/BRIEF.md
# Two-Level Interrupt Priority Controller

This block arbitrates the interrupt requests of a small microcontroller core. It watches five sources: two external pins, two timer overflows and one serial port. It gates them with a master enable and a per-source enable, and sorts them into a low and a high priority class using one bit per source. When the core reports an instruction boundary and a request may be taken, the controller registers a one-cycle take pulse, the entry address of the chosen handler, and a one-hot acknowledge naming the source.

The controller records which priority classes have a handler running. A handler of either class blocks any further request of its own class. A running low-class handler can be preempted by a high-class request, and a running high-class handler blocks everything. Only a return-from-interrupt pulse from the core releases a class, and it releases the highest class that is active. External pins can be level or edge sensitive. Edge events and timer overflows are held in flags that the acknowledge clears. The serial request follows its done flags and is never cleared by this block.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the enable byte, the priority byte, take, ack and the in-service bits are all zero, and the vector is 0x0000.
- R2: The handler entry address is 0x0003 + 8*i for source index i (0 ext0, 1 tmr0, 2 ext1, 3 tmr1, 4 serial), which gives 0x0003, 0x000B, 0x0013, 0x001B and 0x0023.
- R3: Among simultaneous eligible requests of the same class, the lowest index wins: ext0, tmr0, ext1, tmr1, serial.
- R4: A source is eligible only when enable bit 7 (master) and its own enable bit i are both 1. Enable bits 6 and 5 read back as 0.
- R5: Priority bit i set to 1 puts source i in the high class. Priority bits 7..5 read back as 0. The high class is considered before the low class.
- R6: While a low-class handler runs, another low-class request is not taken, but a high-class request is taken and preempts it.
- R7: Take lasts one cycle, with ack one-hot on the chosen source in the same cycle. Taking a timer or an edge-mode external source clears its pending flag.
- R8: The serial request is the OR of the transmit-done and receive-done inputs. Taking it never clears it.
- R9: While the high in-service bit is set, nothing is taken. A return pulse clears the high in-service bit if it is set, and otherwise the low bit.
- R10: Take, vector and ack are registered. They change only from a grant made in a cycle where insn_boundary is 1.
- R11: In level mode (ext_edge_mode bit 0) an external request is the registered pin sample being low, and it is not latched. In edge mode (bit 1) a high-to-low transition sets a flag that stays set until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ien_wr | input | 1 | Write strobe for the enable byte |
| ien_wdata | input | 8 | Enable byte write data |
| ipri_wr | input | 1 | Write strobe for the priority byte |
| ipri_wdata | input | 8 | Priority byte write data |
| ien_q | output | 8 | Enable byte read-back |
| ipri_q | output | 8 | Priority byte read-back |
| ext_pin_n | input | 2 | External request pins, active low |
| ext_edge_mode | input | 2 | Per pin: 1 edge sensitive, 0 level sensitive |
| tmr_ovf | input | 2 | Timer overflow pulses |
| ser_tx_done | input | 1 | Serial transmit-done flag |
| ser_rx_done | input | 1 | Serial receive-done flag |
| insn_boundary | input | 1 | Core is at an instruction boundary |
| reti | input | 1 | Return-from-interrupt pulse |
| take | output | 1 | Registered interrupt-take pulse |
| vector | output | 16 | Registered handler entry address |
| ack | output | 5 | Registered one-hot acknowledge |
| pend | output | 5 | Raw per-source request, before any enable |
| in_service | output | 2 | In-service bits: [1] high class, [0] low class |

## Verification
The bench builds the block with its default parameters: two external and timer pairs, a 16-bit vector with base 3 and stride 8, and an 8-bit register byte with the master enable at bit 7. These values expose all five fixed-order positions and both register bytes with their dead bits. Each vector address can then be compared with the literal value the handler table expects. They also give room for the mixed cases: edge and level pins side by side, a serial source that has no priority field above it, and nested low-then-high service that needs two return pulses to unwind.

// File: rtl/irq_prio_pkg.sv
// Package: shared constants and helpers for the two-level interrupt
// priority controller. Assumes sources are laid out as external/timer
// pairs followed by a single serial source.
package irq_prio_pkg;

    // Source index names for the default five-source arrangement.
    typedef enum logic [2:0] {
        SRC_EXT0 = 3'd0,
        SRC_TMR0 = 3'd1,
        SRC_EXT1 = 3'd2,
        SRC_TMR1 = 3'd3,
        SRC_SER  = 3'd4
    } irq_src_e;

    // In-service bit positions.
    localparam int unsigned LVL_LO = 0;
    localparam int unsigned LVL_HI = 1;

    // Entry address for a source index, given base and stride.
    function automatic logic [31:0] entry_addr(input int unsigned base,
                                               input int unsigned step,
                                               input int unsigned idx);
        return 32'(base + step * idx);
    endfunction

endpackage

// File: rtl/irq_src_flags.sv
// Module: request front end. It samples the external pins, detects
// falling edges, and holds edge and timer flags until they are acknowledged.
// The serial request is the plain OR of the two done flags. Assumes
// index 2k is external k, 2k+1 is timer k, and the last index is serial.
module irq_src_flags #(
    parameter int unsigned PAIRS = 2,
    localparam int unsigned SRC_N = 2 * PAIRS + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PAIRS-1:0] ext_pin_n,
    input  logic [PAIRS-1:0] ext_edge_mode,
    input  logic [PAIRS-1:0] tmr_ovf,
    input  logic             ser_tx_done,
    input  logic             ser_rx_done,
    input  logic [SRC_N-2:0] clr,
    output logic [SRC_N-1:0] req
);

    for (genvar k = 0; k < PAIRS; k++) begin : g_pair
        logic smp_q;
        logic prv_q;
        logic edge_flag_q;
        logic tmr_flag_q;
        logic fall;

        // Register the pin, and keep the previous sample for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                smp_q <= 1'b1;
                prv_q <= 1'b1;
            end else begin
                smp_q <= ext_pin_n[k];
                prv_q <= smp_q;
            end
        end

        assign fall = prv_q & ~smp_q;

        // Edge flag: a new fall sets it, the acknowledge clears it, level mode holds it low.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                edge_flag_q <= 1'b0;
            end else if (!ext_edge_mode[k]) begin
                edge_flag_q <= 1'b0;
            end else if (fall) begin
                edge_flag_q <= 1'b1;
            end else if (clr[2*k]) begin
                edge_flag_q <= 1'b0;
            end
        end

        // Timer flag: an overflow sets it, the acknowledge clears it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tmr_flag_q <= 1'b0;
            end else if (tmr_ovf[k]) begin
                tmr_flag_q <= 1'b1;
            end else if (clr[2*k+1]) begin
                tmr_flag_q <= 1'b0;
            end
        end

        assign req[2*k]   = ext_edge_mode[k] ? edge_flag_q : ~smp_q;
        assign req[2*k+1] = tmr_flag_q;

        assert_tmr_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[2*k+1] && !tmr_ovf[k]) |=> !tmr_flag_q);

        assert_edge_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[2*k] && !fall) |=> !edge_flag_q);
    end

    assign req[SRC_N-1] = ser_tx_done | ser_rx_done;

endmodule

// File: rtl/irq_arbiter.sv
// Module: combinational two-class arbiter. It picks the lowest-index
// eligible source in each class, then applies the preemption rule against
// the in-service bits. It grants only at an instruction boundary.
// Assumes in_service[1] is the high class and in_service[0] the low class.
module irq_arbiter #(
    parameter int unsigned SRC_N = 5
) (
    input  logic [SRC_N-1:0] req,
    input  logic [SRC_N-1:0] src_en,
    input  logic             glb_en,
    input  logic [SRC_N-1:0] pri_hi,
    input  logic [1:0]       in_service,
    input  logic             boundary,
    output logic             grant_valid,
    output logic             grant_hi,
    output logic [SRC_N-1:0] grant
);
    import irq_prio_pkg::*;

    logic [SRC_N-1:0] elig;
    logic [SRC_N-1:0] hi_pick;
    logic [SRC_N-1:0] lo_pick;
    logic             hi_any;
    logic             lo_any;
    logic             take_hi;
    logic             take_lo;

    assign elig = req & src_en & {SRC_N{glb_en}};

    // Fixed-order scan: the first eligible source in each class wins.
    always_comb begin
        hi_pick = '0;
        lo_pick = '0;
        hi_any  = 1'b0;
        lo_any  = 1'b0;
        for (int i = 0; i < int'(SRC_N); i++) begin
            if (elig[i] && pri_hi[i] && !hi_any) begin
                hi_pick[i] = 1'b1;
                hi_any     = 1'b1;
            end
            if (elig[i] && !pri_hi[i] && !lo_any) begin
                lo_pick[i] = 1'b1;
                lo_any     = 1'b1;
            end
        end
    end

    // Preemption rule: high needs no high running; low needs nothing running.
    always_comb begin
        take_hi     = hi_any && !in_service[LVL_HI];
        take_lo     = lo_any && !hi_any && (in_service == 2'b00);
        grant_valid = boundary && (take_hi || take_lo);
        grant_hi    = take_hi;
        grant       = !grant_valid ? '0 : (take_hi ? hi_pick : lo_pick);
    end

endmodule

// File: rtl/irq_level_track.sv
// Module: in-service tracker holding one bit per priority class. A grant
// sets the bit of its class. A return pulse clears the high bit if it is set,
// and the low bit otherwise. A return in the grant cycle acts on the prior state.
module irq_level_track (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_valid,
    input  logic       set_hi,
    input  logic       reti,
    output logic [1:0] in_service
);
    import irq_prio_pkg::*;

    logic [1:0] after_ret;
    logic [1:0] set_mask;

    // Apply the return first, then the new grant.
    always_comb begin
        after_ret = in_service;
        if (reti) begin
            if (in_service[LVL_HI]) after_ret[LVL_HI] = 1'b0;
            else                    after_ret[LVL_LO] = 1'b0;
        end
        set_mask = '0;
        if (set_valid) set_mask[set_hi ? LVL_HI : LVL_LO] = 1'b1;
    end

    // State register for the class bits.
    always_ff @(posedge clk) begin
        if (!rst_n) in_service <= 2'b00;
        else        in_service <= after_ret | set_mask;
    end

    assert_reti_hi_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && in_service[1] && !(set_valid && set_hi)) |=> !in_service[1]);

    assert_reti_keeps_lo_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && in_service == 2'b11) |=> in_service[0]);

endmodule

// File: rtl/irq_prio_ctrl.sv
// Module: top of the two-level interrupt priority controller. It holds the
// enable and priority bytes, wires the request front end, the arbiter and
// the in-service tracker, and registers take, vector and acknowledge.
// Assumes the core holds insn_boundary only where a take is acceptable.
module irq_prio_ctrl #(
    parameter int unsigned PAIRS    = 2,
    parameter int unsigned REG_W    = 8,
    parameter int unsigned GLB_BIT  = 7,
    parameter int unsigned VEC_W    = 16,
    parameter int unsigned VEC_BASE = 3,
    parameter int unsigned VEC_STEP = 8,
    localparam int unsigned SRC_N   = 2 * PAIRS + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ien_wr,
    input  logic [REG_W-1:0] ien_wdata,
    input  logic             ipri_wr,
    input  logic [REG_W-1:0] ipri_wdata,
    output logic [REG_W-1:0] ien_q,
    output logic [REG_W-1:0] ipri_q,
    input  logic [PAIRS-1:0] ext_pin_n,
    input  logic [PAIRS-1:0] ext_edge_mode,
    input  logic [PAIRS-1:0] tmr_ovf,
    input  logic             ser_tx_done,
    input  logic             ser_rx_done,
    input  logic             insn_boundary,
    input  logic             reti,
    output logic             take,
    output logic [VEC_W-1:0] vector,
    output logic [SRC_N-1:0] ack,
    output logic [SRC_N-1:0] pend,
    output logic [1:0]       in_service
);
    import irq_prio_pkg::*;

    localparam logic [REG_W-1:0] SRC_MASK = REG_W'((1 << SRC_N) - 1);
    localparam logic [REG_W-1:0] IEN_MASK = SRC_MASK | (REG_W'(1) << GLB_BIT);

    logic [SRC_N-1:0] req;
    logic [SRC_N-1:0] grant;
    logic             grant_valid;
    logic             grant_hi;
    logic [VEC_W-1:0] vec_next;
    logic             take_q;
    logic [VEC_W-1:0] vec_q;
    logic [SRC_N-1:0] ack_q;

    // Register bytes: write-masked so that unused bits read back as zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q  <= '0;
            ipri_q <= '0;
        end else begin
            if (ien_wr)  ien_q  <= ien_wdata & IEN_MASK;
            if (ipri_wr) ipri_q <= ipri_wdata & SRC_MASK;
        end
    end

    irq_src_flags #(.PAIRS(PAIRS)) u_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .ext_pin_n     (ext_pin_n),
        .ext_edge_mode (ext_edge_mode),
        .tmr_ovf       (tmr_ovf),
        .ser_tx_done   (ser_tx_done),
        .ser_rx_done   (ser_rx_done),
        .clr           (grant[SRC_N-2:0]),
        .req           (req)
    );

    irq_arbiter #(.SRC_N(SRC_N)) u_arb (
        .req         (req),
        .src_en      (ien_q[SRC_N-1:0]),
        .glb_en      (ien_q[GLB_BIT]),
        .pri_hi      (ipri_q[SRC_N-1:0]),
        .in_service  (in_service),
        .boundary    (insn_boundary),
        .grant_valid (grant_valid),
        .grant_hi    (grant_hi),
        .grant       (grant)
    );

    irq_level_track u_lvl (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_valid  (grant_valid),
        .set_hi     (grant_hi),
        .reti       (reti),
        .in_service (in_service)
    );

    // Translate the one-hot grant into the handler entry address.
    always_comb begin
        vec_next = '0;
        for (int i = 0; i < int'(SRC_N); i++) begin
            if (grant[i]) vec_next = VEC_W'(entry_addr(VEC_BASE, VEC_STEP, i));
        end
    end

    // Output registers: take and ack pulse, the vector holds its last value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_q <= 1'b0;
            ack_q  <= '0;
            vec_q  <= '0;
        end else begin
            take_q <= grant_valid;
            ack_q  <= grant;
            if (grant_valid) vec_q <= vec_next;
        end
    end

    assign take   = take_q;
    assign ack    = ack_q;
    assign vector = vec_q;
    assign pend   = req;

    assert_glb_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ien_q[GLB_BIT] |=> !take_q);

    assert_hi_blocks_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_service[1] |=> !take_q);

    assert_take_at_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
        take_q |-> $past(insn_boundary));

    assert_ack_with_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take_q |-> ($countones(ack_q) == 1));

    assert_ack_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !take_q |-> (ack_q == '0));

    assert_lo_blocks_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_service == 2'b01 && (ipri_q[SRC_N-1:0] == '0)) |=> !take_q);

endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ien_wr = 1'b0;
    logic [7:0]  ien_wdata = '0;
    logic        ipri_wr = 1'b0;
    logic [7:0]  ipri_wdata = '0;
    logic [7:0]  ien_q;
    logic [7:0]  ipri_q;
    logic [1:0]  ext_pin_n = 2'b11;
    logic [1:0]  ext_edge_mode = 2'b11;
    logic [1:0]  tmr_ovf = 2'b00;
    logic        ser_tx_done = 1'b0;
    logic        ser_rx_done = 1'b0;
    logic        insn_boundary = 1'b0;
    logic        reti = 1'b0;
    logic        take;
    logic [15:0] vector;
    logic [4:0]  ack;
    logic [4:0]  pend;
    logic [1:0]  in_service;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_prio_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .ien_wr(ien_wr), .ien_wdata(ien_wdata),
        .ipri_wr(ipri_wr), .ipri_wdata(ipri_wdata),
        .ien_q(ien_q), .ipri_q(ipri_q),
        .ext_pin_n(ext_pin_n), .ext_edge_mode(ext_edge_mode),
        .tmr_ovf(tmr_ovf), .ser_tx_done(ser_tx_done), .ser_rx_done(ser_rx_done),
        .insn_boundary(insn_boundary), .reti(reti),
        .take(take), .vector(vector), .ack(ack), .pend(pend),
        .in_service(in_service)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic tick(); @(negedge clk); endtask

    task automatic do_reset();
        rst_n = 1'b0; ien_wr = 0; ipri_wr = 0; ext_pin_n = 2'b11; ext_edge_mode = 2'b11;
        tmr_ovf = 0; ser_tx_done = 0; ser_rx_done = 0; insn_boundary = 0; reti = 0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic wr_ien(input logic [7:0] v);
        ien_wr = 1'b1; ien_wdata = v; tick(); ien_wr = 1'b0;
    endtask

    task automatic wr_ipri(input logic [7:0] v);
        ipri_wr = 1'b1; ipri_wdata = v; tick(); ipri_wr = 1'b0;
    endtask

    task automatic pulse_tmr(input logic [1:0] m);
        tmr_ovf = m; tick(); tmr_ovf = 2'b00;
    endtask

    task automatic fall_ext(input logic [1:0] m);
        ext_pin_n = ext_pin_n & ~m; tick(); tick();
        ext_pin_n = ext_pin_n | m; tick(); tick();
    endtask

    task automatic boundary();
        insn_boundary = 1'b1; tick(); insn_boundary = 1'b0;
    endtask

    task automatic ret_pulse();
        reti = 1'b1; tick(); reti = 1'b0;
    endtask

    // Entry: {ien, ipri, tmr pulses, ext falls, serial, exp take, exp vector low byte}
    localparam int NV = 12;
    localparam logic [29:0] TBL [NV] = '{
        {8'h9F, 8'h00, 2'b11, 2'b11, 1'b1, 1'b1, 8'h03},
        {8'h9F, 8'h00, 2'b11, 2'b10, 1'b1, 1'b1, 8'h0B},
        {8'h9F, 8'h00, 2'b10, 2'b10, 1'b1, 1'b1, 8'h13},
        {8'h9F, 8'h00, 2'b10, 2'b00, 1'b1, 1'b1, 8'h1B},
        {8'h9F, 8'h00, 2'b00, 2'b00, 1'b1, 1'b1, 8'h23},
        {8'h1F, 8'h00, 2'b11, 2'b11, 1'b1, 1'b0, 8'h00},
        {8'h9E, 8'h00, 2'b11, 2'b11, 1'b1, 1'b1, 8'h0B},
        {8'h9F, 8'h10, 2'b11, 2'b11, 1'b1, 1'b1, 8'h23},
        {8'h9F, 8'h0C, 2'b11, 2'b11, 1'b1, 1'b1, 8'h13},
        {8'h9F, 8'h08, 2'b11, 2'b11, 1'b1, 1'b1, 8'h1B},
        {8'h80, 8'h00, 2'b11, 2'b11, 1'b1, 1'b0, 8'h00},
        {8'h90, 8'h00, 2'b11, 2'b11, 1'b0, 1'b0, 8'h00}
    };

    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset();
        check("R1 ien", 32'(ien_q), 32'h00);
        check("R1 ipri", 32'(ipri_q), 32'h00);
        check("R1 take", 32'(take), 32'h0);
        check("R1 vector", 32'(vector), 32'h0000);
        check("R1 ack", 32'(ack), 32'h0);
        check("R1 in_service", 32'(in_service), 32'h0);

        // R4 R5: dead bits read back as zero
        wr_ien(8'hFF);
        check("R4 ien readback", 32'(ien_q), 32'h9F);
        wr_ipri(8'hFF);
        check("R5 ipri readback", 32'(ipri_q), 32'h1F);

        // Table: R2 R3 R4 R5 R7 ordering, gating and classes
        for (int e = 0; e < NV; e++) begin
            logic [29:0] t;
            t = TBL[e];
            do_reset();
            wr_ien(t[29:22]);
            wr_ipri(t[21:14]);
            if (t[13:12] != 0) pulse_tmr(t[13:12]);
            if (t[11:10] != 0) fall_ext(t[11:10]);
            ser_tx_done = t[9];
            tick();
            boundary();
            check($sformatf("R3 take entry %0d", e), 32'(take), 32'(t[8]));
            check($sformatf("R2 vector entry %0d", e), 32'(vector), 32'(t[7:0]));
            check($sformatf("R7 ack entry %0d", e), 32'(ack),
                  t[8] ? (32'h1 << ((32'(t[7:0]) - 3) / 8)) : 32'h0);
            ser_tx_done = 1'b0;
        end

        // R10: no take without boundary, take is a single-cycle pulse
        do_reset();
        wr_ien(8'h82);
        pulse_tmr(2'b01);
        repeat (3) tick();
        check("R10 no boundary no take", 32'(take), 32'h0);
        boundary();
        check("R10 take at boundary", 32'(take), 32'h1);
        check("R7 timer flag cleared", 32'(pend[1]), 32'h0);
        tick();
        check("R10 take one cycle", 32'(take), 32'h0);
        check("R10 vector held", 32'(vector), 32'h000B);

        // R6 R9: nesting and release
        do_reset();
        wr_ien(8'h9F);
        wr_ipri(8'h04);
        pulse_tmr(2'b01);
        boundary();
        check("R6 low taken", 32'(vector), 32'h000B);
        check("R6 low in service", 32'(in_service), 32'h1);
        pulse_tmr(2'b10);
        boundary();
        check("R6 equal class blocked", 32'(take), 32'h0);
        fall_ext(2'b10);
        boundary();
        check("R6 high preempts take", 32'(take), 32'h1);
        check("R6 high preempts vector", 32'(vector), 32'h0013);
        check("R6 both in service", 32'(in_service), 32'h3);
        wr_ipri(8'h0C);
        boundary();
        check("R9 high blocks high", 32'(take), 32'h0);
        ret_pulse();
        check("R9 reti clears high first", 32'(in_service), 32'h1);
        boundary();
        check("R9 high after release", 32'(vector), 32'h001B);
        check("R9 high after release take", 32'(take), 32'h1);
        ret_pulse();
        check("R9 reti high again", 32'(in_service), 32'h1);
        ret_pulse();
        check("R9 reti low", 32'(in_service), 32'h0);

        // R8: serial never cleared
        do_reset();
        wr_ien(8'h90);
        ser_rx_done = 1'b1;
        tick();
        boundary();
        check("R8 rx taken", 32'(vector), 32'h0023);
        check("R8 still pending", 32'(pend[4]), 32'h1);
        ret_pulse();
        boundary();
        check("R8 taken again", 32'(take), 32'h1);
        ser_rx_done = 1'b0; ser_tx_done = 1'b1; tick();
        check("R8 tx alone", 32'(pend[4]), 32'h1);
        ser_tx_done = 1'b0; tick();
        check("R8 both low", 32'(pend[4]), 32'h0);

        // R11: level mode is not latched
        do_reset();
        ext_edge_mode = 2'b00;
        wr_ien(8'h81);
        ext_pin_n = 2'b10; tick();
        ext_pin_n = 2'b11; tick();
        boundary();
        check("R11 short level lost", 32'(take), 32'h0);
        ext_pin_n = 2'b10; tick();
        boundary();
        check("R11 held level taken", 32'(vector), 32'h0003);
        tick();
        check("R11 level stays pending", 32'(pend[0]), 32'h1);
        ret_pulse();
        ext_pin_n = 2'b11; tick();
        check("R11 level released", 32'(pend[0]), 32'h0);

        // R11 R7: edge mode latches, acknowledge clears
        do_reset();
        wr_ien(8'h81);
        fall_ext(2'b01);
        check("R11 edge latched", 32'(pend[0]), 32'h1);
        boundary();
        check("R11 edge taken", 32'(vector), 32'h0003);
        check("R7 edge flag cleared", 32'(pend[0]), 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule